// File: doc/BRIEF.md
# Serial Word EEPROM Target

This block is a synthesizable model of a small serial EEPROM as seen from its pins. It holds a register array of 16-bit words and a write-enable latch. A host drives an active-low select, a serial clock and a data line. The block returns read data on a data output with a separate output-enable, and it shows its programming state on a ready output. A fast system clock samples all four serial inputs through synchronizer flops and finds the serial clock edges, so every decision is made in the system clock domain.

Every frame opens with an 8-bit code that is taken most significant bit first. The first four bits must be 1010, and the last four pick the operation. An 8-bit address follows, sent least significant bit first. A write then carries a 16-bit word, also least significant bit first, and starts a self-timed programming interval that is counted in system clock cycles. During that interval a high level on the write-control input aborts the write. Once a write frame has been taken, the host can raise the select and then lower it while the serial clock is low; the data output then shows whether the block is busy or ready.

States: IDLE (waiting for select), CMD (shifting the 8-bit code), ADDR (shifting the address), RDATA (returning a word), WDATA (shifting the write word), DONE (frame finished or rejected, clocks ignored), PROG (programming interval), POSTW (write over, waiting for deselect). Transitions: IDLE→CMD on select; CMD→ADDR on a valid code, CMD→DONE on an invalid one; ADDR→RDATA for read, ADDR→WDATA for write, ADDR→DONE for enable or disable; WDATA→PROG when the latch is set and write-control is low, otherwise WDATA→DONE; RDATA→DONE after the sixteenth bit; PROG→POSTW on timer expiry or abort; POSTW, DONE and any entry state go →IDLE on deselect.

Top module: `ser_eeprom_tgt`

## Requirements
- R1: A frame is acted on only when its first four bits are 1010 and its operation nibble is 1000 (read), 0100 (write), 0011 (enable writes) or 0000 (disable writes). Any other code changes neither memory nor the ready output.
- R2: The address is taken A0 first. Write data is taken D0 first, and read data is returned D0 first, so a word written at an address reads back bit for bit.
- R3: On a read, DO carries D0 after the falling edge of the 16th serial clock and D15 after the falling edge of the 31st, and the output enable is high while these bits are shown.
- R4: The write-enable latch is clear after reset. A complete write frame sent while the latch is clear starts no programming, and ready stays high.
- R5: Enable and disable take effect at the 16th rising serial clock. Further clocks in the same select window, even a whole write frame, are ignored. Write-control has no effect on either command.
- R6: A write with the latch set and write-control low drives ready low from the 32nd rising serial clock for exactly TEW_CYCLES system clock cycles. The word is stored when that interval ends.
- R7: While programming runs, serial input is ignored. A disable command sent during the interval leaves the latch set.
- R8: Write-control going high during programming ends the interval at once, whatever the select level, and the stored word stays unchanged.
- R9: After a write frame, if the select falls while the serial clock is low, DO shows the status with the output enable high: 0 while busy and 1 once ready.
- R10: Raising the select before a frame completes cancels it with no effect. Raising it after programming returns the block to idle.
- R11: The output enable is low whenever the select is high and outside the read-data and status phases.
- R12: When the select rises in the same system cycle as the 16th rising serial clock of an enable or disable frame, the cancel wins and the latch keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low reset; clears the latch and the state |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial code, address and data input |
| wc | input | 1 | Write control; high aborts programming |
| sdo | output | 1 | Serial data or status value |
| sdo_oe | output | 1 | Drive enable for sdo (low = high impedance) |
| rdy | output | 1 | High when ready, low while programming |

## Verification
Two events can land in the same system cycle: a select rise that cancels a frame, and the 16th rising serial clock that commits an enable or disable. The bench provokes this by changing both pins in the same system cycle at the end of a disable frame. Both pins pass through the same synchronizer depth, so they reach the state machine together. The outcome is judged at the pins: if the following write programs for the full interval, the latch kept its value and the cancel won.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_RDATA,
        ST_WDATA,
        ST_DONE,
        ST_PROG,
        ST_POSTW
    } eep_state_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_READ,
        OP_WRITE,
        OP_WREN,
        OP_WRDIS
    } eep_op_t;

    localparam logic [3:0] START_PAT = 4'b1010;
    localparam logic [3:0] CODE_RD   = 4'b1000;
    localparam logic [3:0] CODE_WR   = 4'b0100;
    localparam logic [3:0] CODE_EN   = 4'b0011;
    localparam logic [3:0] CODE_DIS  = 4'b0000;

    function automatic eep_op_t decode_op(input logic [7:0] code);
        eep_op_t op;
        op = OP_NONE;
        if (code[7:4] == START_PAT) begin
            case (code[3:0])
                CODE_RD:  op = OP_READ;
                CODE_WR:  op = OP_WRITE;
                CODE_EN:  op = OP_WREN;
                CODE_DIS: op = OP_WRDIS;
                default:  op = OP_NONE;
            endcase
        end
        return op;
    endfunction

endpackage

// File: rtl/eep_pin_sync.sv
module eep_pin_sync #(
    parameter int          N       = 4,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    logic [N-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/eep_word_store.sv
module eep_word_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
    parameter int CYCLES = 300,
    localparam int CW    = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);

    logic [CW-1:0] cnt_q;

    assign expire = run && (cnt_q == CW'(CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (run && !expire) cnt_q <= cnt_q + 1'b1;
        else                     cnt_q <= '0;
    end

endmodule

// File: rtl/ser_eeprom_tgt.sv
module ser_eeprom_tgt
    import eep_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int DEPTH       = 256,
    parameter int TEW_CYCLES  = 300,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic sdi,
    input  logic wc,
    output logic sdo,
    output logic sdo_oe,
    output logic rdy
);

    localparam int CMD_W = 8;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DATA_W + 1);

    // synchronized pins
    logic cs_q, sck_q, sdi_q, wc_q;
    logic sck_d, cs_d;
    logic sck_rise, sck_fall, sel_fall;

    eep_pin_sync #(
        .N       (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b0001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({wc, sdi, sck, cs_n}),
        .dout  ({wc_q, sdi_q, sck_q, cs_q})
    );

    assign sck_rise = sck_q && !sck_d;
    assign sck_fall = !sck_q && sck_d;
    assign sel_fall = cs_d && !cs_q;

    // state and datapath registers
    eep_state_t state_q, state_d;
    eep_op_t    op_q;
    logic [CMD_W-2:0]  cmd_sr;
    logic [ADDR_W-1:0] addr_sr;
    logic [DATA_W-1:0] data_sr;
    logic [DATA_W-1:0] rd_sr;
    logic [CNT_W-1:0]  bcnt;
    logic              wel_q;
    logic              rd_bit_q;
    logic              rd_on_q;
    logic              stat_q;

    logic [ADDR_W-1:0] addr_nx;
    logic [DATA_W-1:0] mem_rdata;
    logic              mem_we;
    logic              tmr_expire;
    logic              last_cmd, last_addr, last_wdata, last_rdata;
    eep_op_t           op_nx;

    assign addr_nx    = {sdi_q, addr_sr[ADDR_W-1:1]};
    assign op_nx      = decode_op({cmd_sr, sdi_q});
    assign last_cmd   = sck_rise && (bcnt == CNT_W'(CMD_W - 1));
    assign last_addr  = sck_rise && (bcnt == CNT_W'(ADDR_W - 1));
    assign last_wdata = sck_rise && (bcnt == CNT_W'(DATA_W - 1));
    assign last_rdata = sck_fall && (bcnt == CNT_W'(DATA_W));

    eep_word_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (addr_sr[IDX_W-1:0]),
        .wdata (data_sr),
        .raddr (addr_nx[IDX_W-1:0]),
        .rdata (mem_rdata)
    );

    eep_prog_timer #(
        .CYCLES (TEW_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == ST_PROG),
        .expire (tmr_expire)
    );

    assign mem_we = (state_q == ST_PROG) && tmr_expire && !wc_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!cs_q) state_d = ST_CMD;
            end
            ST_CMD: begin
                if (cs_q)          state_d = ST_IDLE;
                else if (last_cmd) state_d = (op_nx == OP_NONE) ? ST_DONE : ST_ADDR;
            end
            ST_ADDR: begin
                if (cs_q) state_d = ST_IDLE;
                else if (last_addr) begin
                    if (op_q == OP_READ)       state_d = ST_RDATA;
                    else if (op_q == OP_WRITE) state_d = ST_WDATA;
                    else                       state_d = ST_DONE;
                end
            end
            ST_RDATA: begin
                if (cs_q)            state_d = ST_IDLE;
                else if (last_rdata) state_d = ST_DONE;
            end
            ST_WDATA: begin
                if (cs_q)            state_d = ST_IDLE;
                else if (last_wdata) state_d = (wel_q && !wc_q) ? ST_PROG : ST_DONE;
            end
            ST_DONE: begin
                if (cs_q) state_d = ST_IDLE;
            end
            ST_PROG: begin
                if (wc_q || tmr_expire) state_d = ST_POSTW;
            end
            ST_POSTW: begin
                if (cs_q) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d    <= 1'b0;
            cs_d     <= 1'b1;
            bcnt     <= '0;
            cmd_sr   <= '0;
            op_q     <= OP_NONE;
            addr_sr  <= '0;
            data_sr  <= '0;
            rd_sr    <= '0;
            wel_q    <= 1'b0;
            rd_bit_q <= 1'b0;
            rd_on_q  <= 1'b0;
            stat_q   <= 1'b0;
        end else begin
            sck_d <= sck_q;
            cs_d  <= cs_q;

            if (state_d != state_q) begin
                bcnt <= '0;
            end else if ((sck_rise && (state_q == ST_CMD || state_q == ST_ADDR ||
                                       state_q == ST_WDATA)) ||
                         (sck_fall && state_q == ST_RDATA)) begin
                bcnt <= bcnt + 1'b1;
            end

            if (state_q == ST_CMD && sck_rise && !cs_q) begin
                cmd_sr <= {cmd_sr[CMD_W-3:0], sdi_q};
                if (last_cmd) op_q <= op_nx;
            end

            if (state_q == ST_ADDR && sck_rise && !cs_q) begin
                addr_sr <= addr_nx;
                if (last_addr) begin
                    if (op_q == OP_WREN)  wel_q <= 1'b1;
                    if (op_q == OP_WRDIS) wel_q <= 1'b0;
                    if (op_q == OP_READ)  rd_sr <= mem_rdata;
                end
            end

            if (state_q == ST_WDATA && sck_rise && !cs_q)
                data_sr <= {sdi_q, data_sr[DATA_W-1:1]};

            if (state_q == ST_RDATA) begin
                if (sck_fall) begin
                    rd_bit_q <= rd_sr[0];
                    rd_sr    <= {1'b0, rd_sr[DATA_W-1:1]};
                    rd_on_q  <= 1'b1;
                end
            end else begin
                rd_on_q <= 1'b0;
            end

            if (cs_q)
                stat_q <= 1'b0;
            else if ((state_q == ST_PROG || state_q == ST_POSTW) && sel_fall && !sck_q)
                stat_q <= 1'b1;
        end
    end

    // outputs
    logic rdy_c, oe_c, sdo_c;
    always_comb begin
        rdy_c = (state_q != ST_PROG);
        oe_c  = 1'b0;
        sdo_c = rdy_c;
        unique case (state_q)
            ST_RDATA: begin
                oe_c  = rd_on_q && !cs_q;
                sdo_c = rd_bit_q;
            end
            ST_PROG, ST_POSTW: begin
                oe_c  = stat_q && !cs_q;
                sdo_c = rdy_c;
            end
            ST_IDLE, ST_CMD, ST_ADDR, ST_WDATA, ST_DONE: begin
                oe_c  = 1'b0;
            end
            default: oe_c = 1'b0;
        endcase
    end

    assign rdy    = rdy_c;
    assign sdo_oe = oe_c;
    assign sdo    = sdo_c;

endmodule

// File: rtl/eep_chk.sv
module eep_chk
    import eep_pkg::*;
#(
    parameter int TEW_CYCLES = 300,
    localparam int RW = $clog2(TEW_CYCLES + 2)
) (
    input logic       clk,
    input logic       rst_n,
    input eep_state_t state,
    input logic       wel,
    input logic       mem_we,
    input logic       wc_s,
    input logic       cs_s,
    input logic       rdy,
    input logic       sdo_oe
);

    logic [RW-1:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    low_run <= '0;
        else if (!rdy) low_run <= low_run + 1'b1;
        else           low_run <= '0;
    end

    // R6: busy never outlasts the programming interval
    a_r6_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |-> (low_run < RW'(TEW_CYCLES)));

    // R4: a store only happens with the write-enable latch set
    a_r4_store_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wel);

    // R5: the latch only moves at the end of an address phase
    a_r5_latch_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wel) |-> ($past(state) == ST_ADDR));

    // R8: write-control during programming ends busy next cycle
    a_r8_wc_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG && wc_s) |=> rdy);

    // R7: programming can only end in the post-write state
    a_r7_prog_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG) |=> (state == ST_PROG || state == ST_POSTW));

    // R11: never drive the data pin while deselected
    a_r11_oe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> !cs_s);

endmodule

bind ser_eeprom_tgt eep_chk #(
    .TEW_CYCLES (TEW_CYCLES)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .state  (state_q),
    .wel    (wel_q),
    .mem_we (mem_we),
    .wc_s   (wc_q),
    .cs_s   (cs_q),
    .rdy    (rdy),
    .sdo_oe (sdo_oe)
);

// File: tb/ser_eeprom_tgt_tb.sv
module ser_eeprom_tgt_tb;

    localparam int TEW = 300;
    localparam int H   = 6;
    localparam int WATCHDOG = 150000;

    localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_EN = 2'd2, K_DS = 2'd3;
    localparam int NV = 13;
    // {kind[41:40], addr[39:32], data[31:16], expect[15:0]}
    localparam logic [41:0] VEC [NV] = '{
        {K_WR, 8'h05, 16'hBEEF, 16'h0000},
        {K_EN, 8'h00, 16'h0000, 16'h0000},
        {K_WR, 8'h05, 16'hA5C3, 16'h0001},
        {K_DS, 8'h00, 16'h0000, 16'h0000},
        {K_WR, 8'h05, 16'h1234, 16'h0000},
        {K_RD, 8'h05, 16'h0000, 16'hA5C3},
        {K_EN, 8'h00, 16'h0000, 16'h0000},
        {K_WR, 8'hFF, 16'h8001, 16'h0001},
        {K_WR, 8'h00, 16'h7FFE, 16'h0001},
        {K_RD, 8'hFF, 16'h0000, 16'h8001},
        {K_RD, 8'h00, 16'h0000, 16'h7FFE},
        {K_WR, 8'h05, 16'h0F0F, 16'h0001},
        {K_RD, 8'h05, 16'h0000, 16'h0F0F}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, wc = 1'b0;
    logic sdo, sdo_oe, rdy;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    ser_eeprom_tgt #(.TEW_CYCLES(TEW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .wc(wc), .sdo(sdo), .sdo_oe(sdo_oe), .rdy(rdy)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clk_bit(input logic b);
        sdi = b;
        tick(H);
        sck = 1'b1;
        tick(H);
        sck = 1'b0;
    endtask

    task automatic send_msb8(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) clk_bit(v[i]);
    endtask

    task automatic send_lsb(input logic [15:0] v, input int n);
        for (int i = 0; i < n; i++) clk_bit(v[i]);
    endtask

    task automatic sel();
        cs_n = 1'b0;
        tick(H);
    endtask

    task automatic desel();
        tick(H);
        cs_n = 1'b1;
        tick(2 * H);
    endtask

    task automatic write_frame(input logic [7:0] a, input logic [15:0] d);
        sel();
        send_msb8(8'b1010_0100);
        send_lsb({8'h00, a}, 8);
        send_lsb(d, 16);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [15:0] d, output int lowcnt);
        sel();
        send_msb8(8'b1010_0100);
        send_lsb({8'h00, a}, 8);
        send_lsb(d, 15);
        sdi = d[15];
        tick(H);
        sck = 1'b1;
        lowcnt = 0;
        for (int n = 0; n < TEW + 20; n++) begin
            tick(1);
            if (!rdy) lowcnt++;
            if (n == H) sck = 1'b0;
        end
        desel();
    endtask

    task automatic do_read(input logic [7:0] a, output logic [15:0] d, output bit oe_ok);
        sel();
        send_msb8(8'b1010_1000);
        send_lsb({8'h00, a}, 8);
        oe_ok = 1'b1;
        for (int i = 0; i < 16; i++) begin
            tick(H);
            d[i] = sdo;
            if (sdo_oe !== 1'b1) oe_ok = 1'b0;
            sck = 1'b1;
            tick(H);
            sck = 1'b0;
        end
        desel();
    endtask

    task automatic do_short(input logic [3:0] op);
        sel();
        send_msb8({4'b1010, op});
        send_lsb(16'h0000, 8);
        desel();
    endtask

    task automatic wait_ready();
        for (int n = 0; n < TEW + 20; n++) begin
            if (rdy) break;
            tick(1);
        end
    endtask

    // watchdog
    initial begin
        tick(WATCHDOG);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int lc;
        logic [15:0] rd;
        bit ok;

        tick(5);
        rst_n = 1'b1;
        tick(5);
        // reset state
        chk(rdy === 1'b1, "R4 reset rdy", {31'd0, rdy}, 32'd1);
        chk(sdo_oe === 1'b0, "R11 reset oe", {31'd0, sdo_oe}, 32'd0);

        // table of vectors
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][41:40])
                K_WR: begin
                    do_write(VEC[i][39:32], VEC[i][31:16], lc);
                    if (VEC[i][0])
                        chk(lc == TEW, "R6 busy length", lc, TEW);
                    else
                        chk(lc == 0, "R4 locked write", lc, 0);
                end
                K_RD: begin
                    do_read(VEC[i][39:32], rd, ok);
                    chk(rd === VEC[i][15:0], "R2 R3 read data", {16'd0, rd}, {16'd0, VEC[i][15:0]});
                    chk(ok, "R3 oe during read", {31'd0, ok}, 32'd1);
                    chk(sdo_oe === 1'b0, "R11 oe after read", {31'd0, sdo_oe}, 32'd0);
                end
                K_EN: do_short(4'b0011);
                K_DS: do_short(4'b0000);
                default: ;
            endcase
        end

        // R9 status on DO
        write_frame(8'h20, 16'h3333);
        cs_n = 1'b1;
        tick(4);
        chk(sdo_oe === 1'b0, "R11 oe deselected busy", {31'd0, sdo_oe}, 32'd0);
        cs_n = 1'b0;
        tick(6);
        chk(sdo_oe === 1'b1 && sdo === 1'b0, "R9 busy status", {30'd0, sdo_oe, sdo}, 32'd2);
        wait_ready();
        tick(3);
        chk(sdo_oe === 1'b1 && sdo === 1'b1, "R9 ready status", {30'd0, sdo_oe, sdo}, 32'd3);
        cs_n = 1'b1;
        tick(2 * H);
        chk(sdo_oe === 1'b0, "R10 R11 idle after write", {31'd0, sdo_oe}, 32'd0);
        do_read(8'h20, rd, ok);
        chk(rd === 16'h3333, "R6 stored word", {16'd0, rd}, 32'h3333);

        // R8 abort by write control, select high
        do_write(8'h30, 16'h1111, lc);
        write_frame(8'h30, 16'h2222);
        cs_n = 1'b1;
        tick(10);
        chk(rdy === 1'b0, "R6 busy before abort", {31'd0, rdy}, 32'd0);
        wc = 1'b1;
        tick(5);
        chk(rdy === 1'b1, "R8 abort ends busy", {31'd0, rdy}, 32'd1);
        wc = 1'b0;
        tick(2 * H);
        do_read(8'h30, rd, ok);
        chk(rd === 16'h1111, "R8 word unchanged", {16'd0, rd}, 32'h1111);

        // R5 write control ignored, extra clocks ignored
        wc = 1'b1;
        do_short(4'b0000);
        wc = 1'b0;
        do_write(8'h40, 16'h4444, lc);
        chk(lc == 0, "R5 disable with wc high", lc, 0);
        wc = 1'b1;
        sel();
        send_msb8(8'b1010_0011);
        send_lsb(16'h0000, 8);
        wc = 1'b0;
        send_msb8(8'b1010_0100);
        send_lsb(16'h0040, 8);
        send_lsb(16'h5555, 16);
        tick(2);
        chk(rdy === 1'b1, "R5 trailing frame ignored", {31'd0, rdy}, 32'd1);
        desel();
        do_write(8'h40, 16'h4444, lc);
        chk(lc == TEW, "R5 enable with wc high", lc, TEW);
        do_read(8'h40, rd, ok);
        chk(rd === 16'h4444, "R5 word after enable", {16'd0, rd}, 32'h4444);

        // R7 commands ignored while busy
        write_frame(8'h50, 16'h5A5A);
        cs_n = 1'b1;
        tick(4);
        sel();
        send_msb8(8'b1010_0000);
        send_lsb(16'h0000, 8);
        cs_n = 1'b1;
        wait_ready();
        tick(2 * H);
        do_write(8'h51, 16'h6B6B, lc);
        chk(lc == TEW, "R7 disable during busy ignored", lc, TEW);

        // R10 cancel mid-frame
        sel();
        send_msb8(8'b1010_0100);
        send_lsb(16'h0050, 8);
        send_lsb(16'h00FF, 8);
        cs_n = 1'b1;
        tick(2 * H);
        chk(rdy === 1'b1, "R10 cancel no busy", {31'd0, rdy}, 32'd1);
        do_read(8'h50, rd, ok);
        chk(rd === 16'h5A5A, "R10 word unchanged", {16'd0, rd}, 32'h5A5A);

        // R12 select rise coincides with 16th rising clock of disable
        sel();
        send_msb8(8'b1010_0000);
        send_lsb(16'h0000, 7);
        sdi = 1'b0;
        tick(H);
        sck = 1'b1;
        cs_n = 1'b1;
        tick(H);
        sck = 1'b0;
        tick(2 * H);
        do_write(8'h60, 16'h7777, lc);
        chk(lc == TEW, "R12 cancel wins", lc, TEW);

        // R1 bad start pattern
        sel();
        send_msb8(8'b1011_0100);
        send_lsb(16'h0060, 8);
        send_lsb(16'h1111, 16);
        tick(2);
        chk(rdy === 1'b1, "R1 bad code no busy", {31'd0, rdy}, 32'd1);
        desel();
        do_read(8'h60, rd, ok);
        chk(rd === 16'h7777, "R1 word unchanged", {16'd0, rd}, 32'h7777);

        // R4 reset clears latch again
        rst_n = 1'b0;
        tick(4);
        rst_n = 1'b1;
        tick(4);
        do_write(8'h61, 16'h1357, lc);
        chk(lc == 0, "R4 latch clear after reset", lc, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule